// File: doc/BRIEF.md
# Active Request Dispatcher with Address Conflict Check

The dispatcher takes an immediate request that carries a small set of target addresses, each with its own enable bit, and hands it a free command set from the active group. Before any set is handed out, the block compares the request's enabled addresses against the enabled command addresses held by every set that is currently in use. If any address matches, the request is refused as a conflict, even when a free set exists. If there is no conflict, the lowest-indexed free set is claimed. When every set is in use, the request is refused as full.

Each set records the addresses and enable mask of the request it was granted. A set stays in use until its done pulse arrives. The check, the pick and the claim all happen at one clock edge, so a request on the very next cycle already sees the earlier claim.

When the active group is configured with zero sets, the block borrows the wake group instead. Every grant then carries a scrub flag, which tells the command programmer to clear the borrowed set's enable and wait masks before loading it. A controller-busy output shows whether any set of the group in use is occupied.

Top module: `active_dispatch`

## Requirements
- R1: After reset no set is in use, `ctrl_busy_o` is low and `resp_valid_o` is low.
- R2: Sets that are not in use are skipped by the conflict check. Once a set has been released, its addresses no longer cause a conflict.
- R3: Only enabled slots take part in the comparison, on both sides. A request address in a disabled request slot never matches. A stored address in a slot that was disabled at grant time never matches.
- R4: If any enabled request address equals any enabled address of an in-use set, the response has `resp_conflict_o`=1 and `resp_grant_o`=0, and no set is claimed. This holds even when free sets exist, and conflict takes priority over full.
- R5: On a grant, `resp_set_o` is the lowest-numbered free set. Sets are numbered 0 upward within the group in use.
- R6: With no conflict and every set in use, the response has `resp_full_o`=1 and `resp_grant_o`=0.
- R7: A granted set is marked in use. A pulse on `done_i[s]` releases set s at that clock edge. A done pulse for a set that is not in use has no effect.
- R8: Each request gets exactly one response: `resp_valid_o` is high in the cycle after `req_valid_i`, with exactly one of grant, conflict or full set. The decision uses the state left by the previous edge, so back-to-back requests never receive the same set.
- R9: With NUM_ACT=0 the group is the NUM_WAKE wake sets, and `resp_scrub_o` is high with every grant. With NUM_ACT>0, `resp_scrub_o` is always low.
- R10: `ctrl_busy_o` is high exactly when at least one set of the group is in use, as updated by the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_en_i | input | CMDS | Per-slot enable of the request addresses |
| req_addr_i | input | CMDS*ADDR_W | Request addresses, slot k at bits [k*ADDR_W +: ADDR_W] |
| done_i | input | GRP | Completion pulse per set of the group in use |
| resp_valid_o | output | 1 | Response for the previous cycle's request |
| resp_grant_o | output | 1 | Request granted a set |
| resp_conflict_o | output | 1 | Refused: address overlaps an in-use set |
| resp_full_o | output | 1 | Refused: no free set |
| resp_set_o | output | SET_W | Granted set index within the group |
| resp_scrub_o | output | 1 | Granted set is borrowed and must be cleared before use |
| ctrl_busy_o | output | 1 | Any set of the group in use |

## Verification
The main instance is built with NUM_ACT=4, NUM_WAKE=2, CMDS=4 and ADDR_W=8. Random addresses are drawn from a pool of eight values, so conflicts, full refusals and lowest-free picks across all four sets occur often. A second instance is built with NUM_ACT=0 and NUM_WAKE=2, which selects the borrowed wake group. That instance is the only way to reach the scrub flag and the two-set sizing of the group.

// File: rtl/disp_pkg.sv
package disp_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/disp_cmd_set.sv
module disp_cmd_set #(
  parameter int CMDS   = 4,
  parameter int ADDR_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   claim_i,
  input  logic                   release_i,
  input  logic [CMDS-1:0]        req_en_i,
  input  logic [CMDS*ADDR_W-1:0] req_addr_i,
  output logic                   busy_o,
  output logic                   hit_o
);
  localparam int PAIRS = CMDS * CMDS;

  logic [CMDS-1:0]        en_q;
  logic [CMDS*ADDR_W-1:0] addr_q;
  logic [PAIRS-1:0]       pair_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      en_q   <= '0;
      addr_q <= '0;
    end else if (claim_i) begin
      busy_o <= 1'b1;
      en_q   <= req_en_i;
      addr_q <= req_addr_i;
    end else if (release_i) begin
      busy_o <= 1'b0;
      en_q   <= '0;
    end
  end

  // every stored slot against every request slot
  for (genvar j = 0; j < CMDS; j++) begin : g_stored
    for (genvar k = 0; k < CMDS; k++) begin : g_req
      assign pair_hit[j*CMDS+k] = en_q[j] & req_en_i[k] &
        (addr_q[j*ADDR_W +: ADDR_W] == req_addr_i[k*ADDR_W +: ADDR_W]);
    end
  end

  assign hit_o = busy_o & (|pair_hit);
endmodule

// File: rtl/disp_low_pick.sv
module disp_low_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  free_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |free_i;
endmodule

// File: rtl/active_dispatch.sv
module active_dispatch #(
  parameter int NUM_ACT  = 4,
  parameter int NUM_WAKE = 2,
  parameter int CMDS     = 4,
  parameter int ADDR_W   = 16,
  localparam bit BORROW  = (NUM_ACT == 0),
  localparam int GRP     = BORROW ? NUM_WAKE : NUM_ACT,
  localparam int SET_W   = disp_pkg::idx_w(GRP)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [CMDS-1:0]        req_en_i,
  input  logic [CMDS*ADDR_W-1:0] req_addr_i,
  input  logic [GRP-1:0]         done_i,
  output logic                   resp_valid_o,
  output logic                   resp_grant_o,
  output logic                   resp_conflict_o,
  output logic                   resp_full_o,
  output logic [SET_W-1:0]       resp_set_o,
  output logic                   resp_scrub_o,
  output logic                   ctrl_busy_o
);
  logic [GRP-1:0]   busy_vec;
  logic [GRP-1:0]   hit_vec;
  logic [GRP-1:0]   claim_vec;
  logic             pick_any;
  logic [SET_W-1:0] pick_idx;
  logic             conflict;
  logic             take;

  for (genvar s = 0; s < GRP; s++) begin : g_set
    disp_cmd_set #(.CMDS(CMDS), .ADDR_W(ADDR_W)) u_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .claim_i    (claim_vec[s]),
      .release_i  (done_i[s]),
      .req_en_i   (req_en_i),
      .req_addr_i (req_addr_i),
      .busy_o     (busy_vec[s]),
      .hit_o      (hit_vec[s])
    );
    assign claim_vec[s] = take && (pick_idx == SET_W'(s));
  end

  disp_low_pick #(.N(GRP), .IW(SET_W)) u_pick (
    .free_i (~busy_vec),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  assign conflict = |hit_vec;
  assign take     = req_valid_i & ~conflict & pick_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o    <= 1'b0;
      resp_grant_o    <= 1'b0;
      resp_conflict_o <= 1'b0;
      resp_full_o     <= 1'b0;
      resp_set_o      <= '0;
      resp_scrub_o    <= 1'b0;
    end else begin
      resp_valid_o    <= req_valid_i;
      resp_grant_o    <= take;
      resp_conflict_o <= req_valid_i & conflict;
      resp_full_o     <= req_valid_i & ~conflict & ~pick_any;
      resp_set_o      <= take ? pick_idx : '0;
      resp_scrub_o    <= take & BORROW;
    end
  end

  assign ctrl_busy_o = |busy_vec;
endmodule

// File: rtl/disp_checker.sv
module disp_checker #(
  parameter int GRP   = 4,
  parameter int SET_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [GRP-1:0]   done_i,
  input logic [GRP-1:0]   in_use_i,
  input logic             resp_valid_o,
  input logic             resp_grant_o,
  input logic             resp_conflict_o,
  input logic             resp_full_o,
  input logic [SET_W-1:0] resp_set_o,
  input logic             resp_scrub_o,
  input logic             ctrl_busy_o
);
  logic [GRP-1:0] prev_use;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_use <= '0;
    else         prev_use <= in_use_i;
  end

  assert_resp_needs_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i));

  assert_one_outcome_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> ($countones({resp_grant_o, resp_conflict_o, resp_full_o}) == 1));

  assert_quiet_without_resp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(resp_grant_o || resp_conflict_o || resp_full_o));

  assert_grant_was_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_grant_o |-> !prev_use[resp_set_o]);

  assert_grant_marks_use_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_grant_o |-> in_use_i[resp_set_o]);

  assert_busy_falls_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_busy_o) |-> $past(|done_i));

  assert_scrub_with_grant_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_scrub_o |-> resp_grant_o);
endmodule

bind active_dispatch disp_checker #(.GRP(GRP), .SET_W(SET_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .done_i          (done_i),
  .in_use_i        (busy_vec),
  .resp_valid_o    (resp_valid_o),
  .resp_grant_o    (resp_grant_o),
  .resp_conflict_o (resp_conflict_o),
  .resp_full_o     (resp_full_o),
  .resp_set_o      (resp_set_o),
  .resp_scrub_o    (resp_scrub_o),
  .ctrl_busy_o     (ctrl_busy_o)
);

// File: tb/sim_active_dispatch.sv
module sim_active_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int CM = 4;
  localparam int AW = 8;
  localparam int G  = 4;
  localparam int GB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             req_valid = 1'b0;
  logic [CM-1:0]    req_en = '0;
  logic [CM*AW-1:0] req_addr = '0;
  logic [G-1:0]     done = '0;
  logic             r_valid, r_grant, r_conf, r_full, r_scrub, c_busy;
  logic [1:0]       r_set;

  logic             b_valid = 1'b0;
  logic [CM-1:0]    b_en = '0;
  logic [CM*AW-1:0] b_addr = '0;
  logic [GB-1:0]    b_done = '0;
  logic             bo_valid, bo_grant, bo_conf, bo_full, bo_scrub, bo_busy;
  logic [0:0]       bo_set;

  active_dispatch #(.NUM_ACT(4), .NUM_WAKE(2), .CMDS(CM), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_en_i(req_en),
    .req_addr_i(req_addr), .done_i(done), .resp_valid_o(r_valid),
    .resp_grant_o(r_grant), .resp_conflict_o(r_conf), .resp_full_o(r_full),
    .resp_set_o(r_set), .resp_scrub_o(r_scrub), .ctrl_busy_o(c_busy));

  active_dispatch #(.NUM_ACT(0), .NUM_WAKE(GB), .CMDS(CM), .ADDR_W(AW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(b_valid), .req_en_i(b_en),
    .req_addr_i(b_addr), .done_i(b_done), .resp_valid_o(bo_valid),
    .resp_grant_o(bo_grant), .resp_conflict_o(bo_conf), .resp_full_o(bo_full),
    .resp_set_o(bo_set), .resp_scrub_o(bo_scrub), .ctrl_busy_o(bo_busy));

  int total = 0;
  int bad = 0;
  logic [G-1:0]     m_busy = '0;
  logic [CM-1:0]    m_en [G];
  logic [CM*AW-1:0] m_addr [G];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CM*AW-1:0] pack(input logic [AW-1:0] a3, input logic [AW-1:0] a2,
                                            input logic [AW-1:0] a1, input logic [AW-1:0] a0);
    return {a3, a2, a1, a0};
  endfunction

  function automatic bit exp_conflict(input logic [CM-1:0] en, input logic [CM*AW-1:0] a);
    bit c = 1'b0;
    for (int s = 0; s < G; s++)
      for (int j = 0; j < CM; j++)
        for (int k = 0; k < CM; k++)
          if (m_busy[s] && m_en[s][j] && en[k] &&
              m_addr[s][j*AW +: AW] == a[k*AW +: AW]) c = 1'b1;
    return c;
  endfunction

  function automatic int exp_low_free();
    for (int s = 0; s < G; s++) if (!m_busy[s]) return s;
    return -1;
  endfunction

  // one cycle on u0: drive at negedge, check after the next edge
  task automatic step(input bit v, input logic [CM-1:0] en, input logic [CM*AW-1:0] a,
                      input logic [G-1:0] d, input string tag);
    bit e_conf, e_full, e_grant;
    int e_set;
    e_conf  = v && exp_conflict(en, a);
    e_set   = exp_low_free();
    e_full  = v && !e_conf && (e_set < 0);
    e_grant = v && !e_conf && !e_full;
    req_valid = v; req_en = en; req_addr = a; done = d;
    @(negedge clk);
    chk(r_valid == v, {tag, " R8 resp_valid"}, int'(r_valid), int'(v));
    if (v) begin
      chk(r_conf == e_conf, {tag, " R4 conflict"}, int'(r_conf), int'(e_conf));
      chk(r_full == e_full, {tag, " R6 full"}, int'(r_full), int'(e_full));
      chk(r_grant == e_grant, {tag, " R7 grant"}, int'(r_grant), int'(e_grant));
      if (e_grant) chk(int'(r_set) == e_set, {tag, " R5 set"}, int'(r_set), e_set);
      chk(r_scrub == 1'b0, {tag, " R9 no scrub"}, int'(r_scrub), 0);
    end
    m_busy = m_busy & ~d;
    if (e_grant) begin
      m_busy[e_set] = 1'b1;
      m_en[e_set]   = en;
      m_addr[e_set] = a;
    end
    chk(c_busy == (|m_busy), {tag, " R10 ctrl_busy"}, int'(c_busy), int'(|m_busy));
    req_valid = 1'b0; done = '0;
  endtask

  task automatic bstep(input bit v, input logic [AW-1:0] a, input logic [GB-1:0] d,
                       input bit eg, input bit ec, input bit ef, input int es,
                       input bit eb, input string tag);
    b_valid = v; b_en = 4'b0001; b_addr = pack(8'h0, 8'h0, 8'h0, a); b_done = d;
    @(negedge clk);
    if (v) begin
      chk(bo_grant == eg, {tag, " R9 borrowed grant"}, int'(bo_grant), int'(eg));
      chk(bo_conf == ec, {tag, " R4 borrowed conflict"}, int'(bo_conf), int'(ec));
      chk(bo_full == ef, {tag, " R6 borrowed full"}, int'(bo_full), int'(ef));
      chk(bo_scrub == eg, {tag, " R9 scrub"}, int'(bo_scrub), int'(eg));
      if (eg) chk(int'(bo_set) == es, {tag, " R5 borrowed set"}, int'(bo_set), es);
    end
    chk(bo_busy == eb, {tag, " R10 borrowed busy"}, int'(bo_busy), int'(eb));
    b_valid = 1'b0; b_done = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R8 act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < G; s++) begin m_en[s] = '0; m_addr[s] = '0; end
    repeat (3) @(negedge clk);
    chk(r_valid == 1'b0, "R1 resp_valid in reset", int'(r_valid), 0);
    chk(c_busy == 1'b0, "R1 ctrl_busy in reset", int'(c_busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(c_busy == 1'b0 && bo_busy == 1'b0, "R1 idle after reset", int'(c_busy), 0);

    // directed: first grant, back-to-back conflict with free sets left
    step(1, 4'b0011, pack(8'h0, 8'h0, 8'h22, 8'h11), '0, "R5 first");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h22), '0, "R4 back-to-back overlap");
    // R3: disabled request slot holds 11 (live in set0) and must not match
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h11, 8'h33), '0, "R3 disabled req slot");
    // R3: stored disabled slot of set1 holds 11; 44 only needs a free set
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h44, 8'h44), '0, "R3 fill");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h55), '0, "R5 last set");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h66), '0, "R6 all busy");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h55), '0, "R4 conflict over full");
    step(0, '0, '0, 4'b0010, "R7 release set1");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h77), '0, "R5 reuse set1");
    step(0, '0, '0, 4'b0001, "R7 release set0");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h11), '0, "R2 released addr free");
    step(1, 4'b0001, pack(8'h0, 8'h0, 8'h0, 8'h22), 4'b0100, "R7 done with request");
    step(0, '0, '0, 4'b1111, "R10 all released");
    step(0, '0, '0, 4'b0001, "R7 done on free set");
    step(1, 4'b1111, pack(8'h1, 8'h1, 8'h1, 8'h1), '0, "R5 after idle");

    // random mix
    for (int n = 0; n < 800; n++) begin
      logic [CM*AW-1:0] a;
      for (int k = 0; k < CM; k++) a[k*AW +: AW] = AW'($urandom % 8);
      step(($urandom % 3) != 0, CM'($urandom), a,
           (($urandom % 4) == 0) ? G'($urandom) : '0, "rand");
    end

    // borrowed wake group
    bstep(1, 8'h05, '0, 1, 0, 0, 0, 1, "R9 borrow0");
    bstep(1, 8'h06, '0, 1, 0, 0, 1, 1, "R9 borrow1");
    bstep(1, 8'h07, '0, 0, 0, 1, 0, 1, "R6 borrow full");
    bstep(1, 8'h05, '0, 0, 1, 0, 0, 1, "R4 borrow overlap");
    bstep(0, 8'h00, 2'b01, 0, 0, 0, 0, 1, "R7 borrow release");
    bstep(1, 8'h07, '0, 1, 0, 0, 0, 1, "R5 borrow reuse");
    bstep(0, 8'h00, 2'b11, 0, 0, 0, 0, 0, "R10 borrow idle");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule